// File: doc/BRIEF.md
# Transmit Buffer Priority Selector

This block decides which of several transmit message buffers in a CAN controller sends next. Each buffer has an unsigned local priority value and an empty flag. A flag value of 1 means the buffer is empty, and 0 means it holds a pending message. When the frame engine signals that a start-of-frame is about to be sent, the block compares the priority values of the pending buffers and latches a winner. The smallest value wins. If two values are equal, the lower buffer index wins.

The block keeps the winner as a one-hot grant and as a binary index for the whole frame. Once the frame completes, the block pulses a one-cycle request to set the winner's empty flag and then returns to idle. The flag register, the buffer contents and the serialiser are outside this block. The block only reads the flags and asks for one of them to be set.

Top module: `tx_slot_picker`

## Requirements
- R1: While reset is held, and in the first cycle after it, `grant_o`, `valid_o`, `index_o` and `txe_set_o` are all zero.
- R2: Bit i of `txe_i` is the empty flag of buffer i (bit 2 for buffer 2, bit 0 for buffer 0). Only buffers whose flag is 0 take part in selection. A buffer whose flag is 1 is never granted, whatever its priority.
- R3: Buffer i's priority is the unsigned value in `prio_i[8*i+7:8*i]`. Among the eligible buffers, the one with the numerically smallest value is granted.
- R4: When eligible buffers share the smallest priority value, the one with the lowest index is granted.
- R5: A pre-SOF strobe that arrives while idle and with every flag set leaves `valid_o` low and `grant_o` zero.
- R6: A pre-SOF strobe sampled while idle, with at least one eligible buffer, raises `valid_o` one cycle later. In the same cycle `grant_o` is one-hot at the winner and `index_o` holds the winner's number. While `valid_o` is low, `grant_o` and `index_o` are zero.
- R7: While `valid_o` is high, changes on `prio_i` or `txe_i` and further pre-SOF strobes do not alter the grant or the index.
- R8: A transmit-complete pulse sampled while `valid_o` is high clears `valid_o`, `grant_o` and `index_o` one cycle later. In that same cycle `txe_set_o` is high for exactly one cycle, at the granted buffer's bit only.
- R9: A transmit-complete pulse sampled while idle has no effect. `txe_set_o` stays zero and no grant appears.
- R10: When transmit-complete and pre-SOF arrive together while `valid_o` is high, the completion is taken and no new selection is made. The block is idle the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| prio_i | input | 24 | Local priority values, 8 bits per buffer, buffer 0 in the low byte |
| txe_i | input | 3 | Empty flags, 1 = empty, bit i for buffer i |
| pre_sof_i | input | 1 | Strobe: start of frame is about to be sent |
| tx_done_i | input | 1 | Pulse: current frame completed successfully |
| grant_o | output | 3 | One-hot grant of the selected buffer |
| valid_o | output | 1 | A grant is held |
| index_o | output | 2 | Binary number of the granted buffer |
| txe_set_o | output | 3 | One-cycle request to set the winner's empty flag |

## Verification
Every result arrives exactly one clock edge after the cycle whose inputs caused it. This holds for the grant, valid and index after a strobe, the release after a completion, and the flag-set pulse. The driver applies each cycle's inputs on the falling edge and pushes the expected outputs for the next rising edge into a queue. The monitor pops one item per rising edge and compares it a short delay after that edge, so each comparison sees only the register update from that single edge. The assertions check the same one-edge relation, comparing each result against the previous cycle's inputs through `$past`.

// File: rtl/tx_slot_picker_pkg.sv
package tx_slot_picker_pkg;
  localparam int unsigned TSP_NBUF_DFLT = 3;
  localparam int unsigned TSP_PW_DFLT   = 8;

  // strict comparison: an equal value never displaces an earlier candidate
  function automatic logic prio_beats(input logic [31:0] cand, input logic [31:0] best);
    return cand < best;
  endfunction

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tsp_eligible.sv
module tsp_eligible #(
  parameter int unsigned NBUF = 3
) (
  input  logic [NBUF-1:0] txe,
  output logic [NBUF-1:0] elig,
  output logic            any
);
  for (genvar g = 0; g < NBUF; g++) begin : g_elig
    assign elig[g] = ~txe[g];
  end
  assign any = |elig;
endmodule

// File: rtl/tsp_arbiter.sv
module tsp_arbiter
  import tx_slot_picker_pkg::*;
#(
  parameter int unsigned NBUF = 3,
  parameter int unsigned PW   = 8,
  localparam int unsigned IW  = idx_width(NBUF)
) (
  input  logic [NBUF*PW-1:0] prio,
  input  logic [NBUF-1:0]    elig,
  output logic               found,
  output logic [IW-1:0]      win_idx
);
  logic [NBUF-1:0] f_c;
  logic [PW-1:0]   p_c [NBUF];
  logic [IW-1:0]   i_c [NBUF];

  for (genvar g = 0; g < NBUF; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign f_c[0] = elig[0];
      assign p_c[0] = prio[PW-1:0];
      assign i_c[0] = '0;
    end else begin : g_next
      logic [PW-1:0] mine;
      logic          take;
      assign mine   = prio[g*PW +: PW];
      assign take   = elig[g] && (!f_c[g-1] || prio_beats(32'(mine), 32'(p_c[g-1])));
      assign f_c[g] = f_c[g-1] | elig[g];
      assign p_c[g] = take ? mine : p_c[g-1];
      assign i_c[g] = take ? IW'(g) : i_c[g-1];
    end
  end

  assign found   = f_c[NBUF-1];
  assign win_idx = i_c[NBUF-1];
endmodule

// File: rtl/tsp_hold.sv
module tsp_hold #(
  parameter int unsigned NBUF = 3,
  parameter int unsigned IW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            done,
  input  logic            found,
  input  logic [IW-1:0]   sel_idx,
  output logic            valid,
  output logic [IW-1:0]   idx,
  output logic [NBUF-1:0] set_pulse,
  output logic            ev_latch,
  output logic            ev_release
);
  assign ev_release = valid && done;
  assign ev_latch   = !valid && start && found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      idx       <= '0;
      set_pulse <= '0;
    end else begin
      set_pulse <= '0;
      if (ev_release) begin
        valid     <= 1'b0;
        idx       <= '0;
        set_pulse <= NBUF'(1) << idx;
      end else if (ev_latch) begin
        valid <= 1'b1;
        idx   <= sel_idx;
      end
    end
  end
endmodule

// File: rtl/tx_slot_picker.sv
module tx_slot_picker
  import tx_slot_picker_pkg::*;
#(
  parameter int unsigned NBUF = TSP_NBUF_DFLT,
  parameter int unsigned PW   = TSP_PW_DFLT,
  localparam int unsigned IW  = idx_width(NBUF)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NBUF*PW-1:0] prio_i,
  input  logic [NBUF-1:0]    txe_i,
  input  logic               pre_sof_i,
  input  logic               tx_done_i,
  output logic [NBUF-1:0]    grant_o,
  output logic               valid_o,
  output logic [IW-1:0]      index_o,
  output logic [NBUF-1:0]    txe_set_o
);
  logic [NBUF-1:0] elig;
  logic            any_pending;
  logic            sel_found;
  logic [IW-1:0]   sel_idx;
  logic            ev_latch;
  logic            ev_release;

  tsp_eligible #(.NBUF(NBUF)) u_elig (
    .txe (txe_i),
    .elig(elig),
    .any (any_pending)
  );

  tsp_arbiter #(.NBUF(NBUF), .PW(PW)) u_arb (
    .prio   (prio_i),
    .elig   (elig),
    .found  (sel_found),
    .win_idx(sel_idx)
  );

  tsp_hold #(.NBUF(NBUF), .IW(IW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (pre_sof_i),
    .done      (tx_done_i),
    .found     (sel_found && any_pending),
    .sel_idx   (sel_idx),
    .valid     (valid_o),
    .idx       (index_o),
    .set_pulse (txe_set_o),
    .ev_latch  (ev_latch),
    .ev_release(ev_release)
  );

  assign grant_o = valid_o ? (NBUF'(1) << index_o) : '0;
endmodule

// File: rtl/tx_slot_picker_chk.sv
module tx_slot_picker_chk #(
  parameter int unsigned NBUF = 3,
  parameter int unsigned PW   = 8,
  parameter int unsigned IW   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NBUF*PW-1:0] prio_i,
  input logic [NBUF-1:0]    txe_i,
  input logic               pre_sof_i,
  input logic               tx_done_i,
  input logic [NBUF-1:0]    grant_o,
  input logic               valid_o,
  input logic [IW-1:0]      index_o,
  input logic [NBUF-1:0]    txe_set_o,
  input logic               ev_latch,
  input logic               ev_release
);
  function automatic logic winner_ok(input logic [NBUF*PW-1:0] p,
                                     input logic [NBUF-1:0] e, input int unsigned w);
    logic [PW-1:0] pw;
    if (w >= NBUF || e[w]) return 1'b0;
    pw = p[w*PW +: PW];
    for (int j = 0; j < NBUF; j++) begin
      if (!e[j] && (p[j*PW +: PW] < pw)) return 1'b0;
      if (!e[j] && (p[j*PW +: PW] == pw) && (j < int'(w))) return 1'b0;
    end
    return 1'b1;
  endfunction

  // R6: grant matches valid and index
  a_r6_grant_shape: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (valid_o == (grant_o != '0)) &&
    (!valid_o || grant_o == (NBUF'(1) << index_o)) && (valid_o || index_o == '0));

  // R2 R3 R4: the latched winner is the best eligible buffer of the strobe cycle
  a_r3_best_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_sof_i && !valid_o && (txe_i != '1)) |=>
      valid_o && winner_ok($past(prio_i), $past(txe_i), int'(index_o)));

  // R5: nothing to pick, nothing granted
  a_r5_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && (txe_i == '1)) |=> !valid_o);

  // R7: grant held through the frame
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !tx_done_i) |=> valid_o && $stable(grant_o) && $stable(index_o));

  // R8 R10: completion releases and pulses the winner's flag
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && tx_done_i) |=> !valid_o && (txe_set_o == $past(grant_o)));

  // R9: no flag request without a held grant completing
  a_r9_no_stray_set: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && tx_done_i) |=> (txe_set_o == '0));

  // internal events line up with the port behaviour
  a_r6_latch_event: assert property (@(posedge clk) disable iff (!rst_n)
    ev_latch |=> $rose(valid_o));
  a_r8_release_event: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |=> $fell(valid_o));
endmodule

bind tx_slot_picker tx_slot_picker_chk #(.NBUF(NBUF), .PW(PW), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prio_i    (prio_i),
  .txe_i     (txe_i),
  .pre_sof_i (pre_sof_i),
  .tx_done_i (tx_done_i),
  .grant_o   (grant_o),
  .valid_o   (valid_o),
  .index_o   (index_o),
  .txe_set_o (txe_set_o),
  .ev_latch  (ev_latch),
  .ev_release(ev_release)
);

// File: tb/tx_slot_picker_test.sv
`timescale 1ns/1ps
module tx_slot_picker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] prio_i = '0;
  logic [2:0]  txe_i = 3'b111;
  logic        pre_sof_i = 1'b0;
  logic        tx_done_i = 1'b0;
  logic [2:0]  grant_o;
  logic        valid_o;
  logic [1:0]  index_o;
  logic [2:0]  txe_set_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  typedef struct {
    logic       valid;
    logic [1:0] idx;
    logic [2:0] set;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // bench view of the block state
  logic       m_valid = 0;
  logic [1:0] m_idx = 0;

  always #4 clk = ~clk;

  tx_slot_picker uut (
    .clk(clk), .rst_n(rst_n), .prio_i(prio_i), .txe_i(txe_i),
    .pre_sof_i(pre_sof_i), .tx_done_i(tx_done_i), .grant_o(grant_o),
    .valid_o(valid_o), .index_o(index_o), .txe_set_o(txe_set_o)
  );

  function automatic int pick(input logic [7:0] p0, p1, p2, input logic [2:0] e);
    logic [7:0] pv [3];
    int best = -1;
    pv[0] = p0; pv[1] = p1; pv[2] = p2;
    for (int k = 0; k < 3; k++)
      if (!e[k] && (best < 0 || pv[k] < pv[best])) best = k;
    return best;
  endfunction

  task automatic cycle(input logic [7:0] p0, p1, p2, input logic [2:0] e,
                       input logic sof, input logic done, input string tag);
    exp_t x;
    int w;
    @(negedge clk);
    prio_i = {p2, p1, p0}; txe_i = e; pre_sof_i = sof; tx_done_i = done;
    x.set = 3'b000;
    if (m_valid) begin
      if (done) begin
        x.set = 3'b001 << m_idx;
        m_valid = 0; m_idx = 0;
      end
    end else if (sof) begin
      w = pick(p0, p1, p2, e);
      if (w >= 0) begin m_valid = 1; m_idx = 2'(w); end
    end
    x.valid = m_valid; x.idx = m_idx; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic check(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t x;
        logic [2:0] g;
        x = sb.pop_front();
        g = x.valid ? (3'b001 << x.idx) : 3'b000;
        check(valid_o === x.valid && grant_o === g && index_o === (x.valid ? x.idx : 2'd0)
              && txe_set_o === x.set, x.tag,
              $sformatf("valid/grant/index/set actual %0b/%03b/%0d/%03b expected %0b/%03b/%0d/%03b",
                        valid_o, grant_o, index_o, txe_set_o, x.valid, g,
                        x.valid ? x.idx : 2'd0, x.set));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(valid_o === 0 && grant_o === 0 && index_o === 0 && txe_set_o === 0, "R1",
          $sformatf("in reset actual %0b/%03b/%0d/%03b expected 0/000/0/000",
                    valid_o, grant_o, index_o, txe_set_o));
    @(negedge clk); rst_n = 1'b1;
    cycle(8'd0, 8'd0, 8'd0, 3'b111, 0, 0, "R1 after reset");
    cycle(8'd1, 8'd2, 8'd3, 3'b000, 0, 1, "R9 done while idle");
    cycle(8'd1, 8'd2, 8'd3, 3'b111, 1, 0, "R5 all empty");
    cycle(8'd30, 8'd10, 8'd20, 3'b000, 1, 0, "R3 R6 smallest wins buf1");
    cycle(8'd0, 8'd10, 8'd20, 3'b000, 1, 0, "R7 prio change and strobe ignored");
    cycle(8'd0, 8'd10, 8'd20, 3'b111, 0, 0, "R7 flag change ignored");
    cycle(8'd0, 8'd10, 8'd20, 3'b000, 0, 1, "R8 release buf1");
    cycle(8'd0, 8'd10, 8'd20, 3'b000, 0, 0, "R8 pulse lasts one cycle");
    cycle(8'd5, 8'd5, 8'd5, 3'b000, 1, 0, "R4 three-way tie buf0");
    cycle(8'd5, 8'd5, 8'd5, 3'b000, 0, 1, "R8 release buf0");
    cycle(8'd0, 8'd9, 8'd7, 3'b001, 1, 0, "R2 empty buf0 skipped");
    cycle(8'd0, 8'd9, 8'd7, 3'b001, 1, 1, "R10 done beats strobe");
    cycle(8'd0, 8'd9, 8'd7, 3'b001, 0, 0, "R10 stays idle");
    cycle(8'd9, 8'd4, 8'd4, 3'b001, 1, 0, "R4 tie buf1 over buf2");
    cycle(8'd9, 8'd4, 8'd4, 3'b001, 0, 1, "R8 release buf1 again");
    cycle(8'd255, 8'd255, 8'd254, 3'b000, 1, 0, "R3 boundary 254 beats 255");
    cycle(8'd255, 8'd255, 8'd254, 3'b000, 0, 1, "R8 release buf2");
    cycle(8'd0, 8'd0, 8'd255, 3'b011, 1, 0, "R2 only buf2 pending");
    cycle(8'd0, 8'd0, 8'd255, 3'b011, 0, 1, "R8 release lone buf2");
    cycle(8'd0, 8'd0, 8'd0, 3'b111, 0, 0, "R9 idle quiet");
    repeat (3) @(posedge clk);
    #3;
    finish_run();
  end
endmodule